// File: doc/BRIEF.md
# UART Oversampling Rate Generator

This block turns a fast reference clock into the timing enables that one serial channel needs. Software loads a 16-bit divisor as two byte-wide registers and sets a control register. The control register has two fields. One picks a front-end prescale of 1 or 4. The other picks 8 or 16 samples per bit. The block then emits `sample_tick`, a one-cycle enable at the oversampling rate, and `bit_tick`, a one-cycle enable once per bit period. The transmit and receive shifters of the channel run from these enables.

The sample tick period, in reference clocks, is `P * D`. Here P is the prescale (1 or 4) and D is the divisor, with 0 taken as 1. The bit period is `P * D * N`, where N is 8 or 16. A 50 MHz reference with P = 1 and D = 1 gives 6.25 Mbit/s in 8x mode and 3.125 Mbit/s in 16x mode. A 14.7456 MHz reference with P = 1 in 8x mode gives about 1.84 Mbit/s. Any register write restarts the whole chain, so a new setting takes effect from a clean phase.

Top module: `baud_gen`

## Requirements
- R1: A synchronous active-high reset drives both ticks low. It clears the divisor to 0 and selects prescale 1 and 16x. So after reset, `sample_tick` is high every cycle and `bit_tick` comes on every 16th sample tick.
- R2: The divisor is 16 bits. Address 0 writes its low byte and address 1 writes its high byte.
- R3: A divisor value of 0 behaves exactly like a divisor of 1.
- R4: Address 2 bit 0 selects the prescale: 0 divides by 1 and 1 divides by 4.
- R5: Address 2 bit 1 selects the oversampling: 0 gives 16 sample ticks per bit and 1 gives 8.
- R6: Consecutive sample ticks are exactly `P*D` clocks apart. When `P*D` > 1, each sample tick is high for exactly one cycle.
- R7: `bit_tick` is only high together with `sample_tick`. Consecutive bit ticks are exactly N sample ticks apart.
- R8: A write to address 0, 1 or 2 restarts the counters. The first sample tick is high in the cycle after the `P*D+1`-th rising edge that follows the capturing edge. The first bit tick falls on the N-th sample tick after the restart.
- R9: A write to address 3 is ignored. The sample tick phase and period carry on unchanged, and so does the bit tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 = divisor low, 1 = divisor high, 2 = control |
| wr_data | input | 8 | Write data |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit-period enable, aligned with a sample tick |

## Verification
A wrong divisor or prescale count shows up as a sample tick spacing other than `P*D`, and this is visible within one sample period. A wrong oversampling count shows up as a bit tick on the wrong sample tick, and this is visible within one bit period. A missing or spurious restart moves the first tick after a write away from the `P*D+1` cycle point. A bit tick that is not aligned with a sample tick is caught on the very cycle it occurs.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic ovs_8x;    // bit 1: 1 = 8 samples per bit
    logic pre_div4;  // bit 0: 1 = prescale by 4
  } baud_ctrl_t;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic [DIV_W-1:0]     divisor,
  output baud_ctrl_t           ctrl,
  output logic                 reload
);
  localparam int unsigned NBYTES = DIV_W / BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NBYTES);

  logic [DIV_W-1:0] div_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        div_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        div_q[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= 1'b0;
    end else begin
      if (wr_en && wr_addr == CTRL_A)
        ctrl <= baud_ctrl_t'(wr_data[1:0]);
      reload <= wr_en && (wr_addr <= CTRL_A);
    end
  end

  assign divisor = div_q;

  // R4 R5
  ctrl_update_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_A) |=> (ctrl == baud_ctrl_t'($past(wr_data[1:0]))));

  // R9
  ignore_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > CTRL_A) |=> !reload);
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic div_sel,
  output logic pre_en
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (cnt == PRE_LAST)
      cnt <= '0;
    else
      cnt <= cnt + PRE_W'(1);
  end

  assign pre_en = !div_sel || (cnt == PRE_LAST);

  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (div_sel && pre_en && !restart) |=> (!pre_en || !div_sel));
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [DIV_W-1:0] divisor,
  output logic             sample_now,
  output logic             sample_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_last;

  // a zero divisor runs as one
  assign div_last   = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign sample_now = step && (cnt >= div_last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt         <= '0;
      sample_tick <= 1'b0;
    end else begin
      sample_tick <= sample_now;
      if (sample_now)
        cnt <= '0;
      else if (step)
        cnt <= cnt + DIV_W'(1);
    end
  end

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !sample_tick);
endmodule

// File: rtl/baud_oversampler.sv
module baud_oversampler #(
  parameter int unsigned OVS_HI = 16,
  parameter int unsigned OVS_LO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic mode_lo,
  input  logic sample_now,
  output logic bit_tick
);
  localparam int unsigned OVS_W = $clog2(OVS_HI);
  localparam logic [OVS_W-1:0] LAST_HI = OVS_W'(OVS_HI - 1);
  localparam logic [OVS_W-1:0] LAST_LO = OVS_W'(OVS_LO - 1);

  logic [OVS_W-1:0] cnt;
  logic [OVS_W-1:0] last;
  logic             wrap;

  assign last = mode_lo ? LAST_LO : LAST_HI;
  assign wrap = sample_now && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt      <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= wrap;
      if (wrap)
        cnt <= '0;
      else if (sample_now)
        cnt <= cnt + OVS_W'(1);
    end
  end

  // R7
  bit_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !restart) |=> !bit_tick);
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned PRE_DIV = 4,
  parameter int unsigned OVS_HI  = 16,
  parameter int unsigned OVS_LO  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  logic [DIV_W-1:0] divisor;
  baud_ctrl_t       ctrl;
  logic             reload;
  logic             pre_en;
  logic             sample_now;

  baud_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .divisor(divisor), .ctrl(ctrl), .reload(reload)
  );

  baud_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(reload),
    .div_sel(ctrl.pre_div4), .pre_en(pre_en)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(reload), .step(pre_en),
    .divisor(divisor), .sample_now(sample_now), .sample_tick(sample_tick)
  );

  baud_oversampler #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_ovs (
    .clk(clk), .rst(rst), .restart(reload), .mode_lo(ctrl.ovs_8x),
    .sample_now(sample_now), .bit_tick(bit_tick)
  );

  // R7
  bit_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sample_tick && !bit_tick));
endmodule

// File: tb/baud_gen_bench.sv
module baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sample_tick;
  logic       bit_tick;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  baud_gen u_baud_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // starts at a negedge where sample_tick was seen (already counted in n0)
  task automatic count_to_bit(input int pd, input int n_exp, input int n0, input string req);
    int n = n0;
    int gap;
    int guard = 0;
    while (guard < 64) begin
      guard++;
      gap = 0;
      do begin
        @(posedge clk); @(negedge clk); gap++;
        if (bit_tick && !sample_tick) check(1'b0, "R7 bit without sample", 1, 0);
      end while (!sample_tick && gap < 70000);
      check(gap == pd, {req, " R6 sample gap"}, gap, pd);
      n++;
      if (bit_tick) break;
    end
    check(n == n_exp, {req, " R7 samples per bit"}, n, n_exp);
  endtask

  // write, then check restart latency, first bit tick and a full bit period
  task automatic wr_check(input logic [1:0] a, input logic [7:0] d,
                          input int pd, input int n, input string req);
    int lat = 0;
    wr(a, d);
    do begin
      @(posedge clk); @(negedge clk); lat++;
    end while (!sample_tick && lat < 70000);
    check(lat == pd + 1, {req, " R8 restart latency"}, lat, pd + 1);
    count_to_bit(pd, n, 1, {req, " R8 first bit"});
    count_to_bit(pd, n, 0, req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!sample_tick && !bit_tick, "R1 ticks low in reset", sample_tick + bit_tick, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(sample_tick == 1'b1, "R1 R3 default divisor runs as 1", sample_tick, 1);
    count_to_bit(1, 16, 1, "R1 default 16x");
  endtask

  task automatic t_low_byte();
    wr_check(2'd0, 8'd5, 5, 16, "R2 low byte 5");
  endtask

  task automatic t_high_byte();
    wr(2'd0, 8'd2);
    wr_check(2'd1, 8'd1, 258, 16, "R2 high byte 258");
    wr(2'd1, 8'd0);
  endtask

  task automatic t_prescale();
    wr(2'd0, 8'd3);
    wr_check(2'd2, 8'h01, 12, 16, "R4 prescale 4 div 3");
  endtask

  task automatic t_ovs8();
    wr_check(2'd2, 8'h02, 3, 8, "R5 8x div 3");
    wr_check(2'd0, 8'd1, 1, 8, "R5 8x fastest");
    wr_check(2'd2, 8'h03, 4, 8, "R5 R4 8x prescale 4");
  endtask

  task automatic t_zero();
    wr_check(2'd0, 8'd0, 4, 8, "R3 zero divisor prescale 4");
    wr_check(2'd2, 8'h00, 1, 16, "R3 zero divisor prescale 1");
  endtask

  task automatic t_ignore();
    int gap = 0;
    wr(2'd2, 8'h00);
    wr_check(2'd0, 8'd5, 5, 16, "R9 setup");
    // now at a bit tick; issue an ignored write right here
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFF;
    @(posedge clk); @(negedge clk); gap++;
    wr_en = 1'b0;
    while (!sample_tick && gap < 100) begin
      @(posedge clk); @(negedge clk); gap++;
    end
    check(gap == 5, "R9 phase kept after ignored write", gap, 5);
    count_to_bit(5, 16, 1, "R9 bit spacing kept");
    count_to_bit(5, 16, 0, "R9 settings kept");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_low_byte();
    t_high_byte();
    t_prescale();
    t_ovs8();
    t_zero();
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule